// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Doorbell Flags

This block is a two-port synchronous memory, 4096 words of 18 bits by default, in which each port reads and writes any location on its own. Two words at the top of the address space also serve as doorbells between the ports. Each doorbell word can hold an 18-bit message.

When the right port writes the left doorbell word, the left port's active-low interrupt output goes low. When the left port writes the right doorbell word, the right port's interrupt output goes low. A port takes down its own interrupt by reading its own doorbell word. Software on one side posts a message and rings the other side with a single write. The other side fetches the message and acknowledges it with a single read.

An enable input turns the doorbells off. Both words then behave as plain storage and neither flag moves.

Top module: `mbx_doorbell_ram`

## Requirements
- R1: After reset both interrupt outputs (lIntN, rIntN) are high and both read-data outputs are zero.
- R2: A port read (ce=1, we=0) returns the array word at the presented address on its read-data output after the next rising clock edge. The output holds until the next read. Reads see the contents from before any write made in the same cycle, and the two ports work independently.
- R3: With intrEn=1, a right-port write (rCe=1, rWe=1) to address DEPTH-2 (0xFFE by default) drives lIntN low after that clock edge.
- R4: With intrEn=1, a left-port access to DEPTH-2 with lCe=1 and lOe=1 returns lIntN high after that edge, whatever the value of lWe.
- R5: With intrEn=1, a left-port write to address DEPTH-1 (0xFFF by default) drives rIntN low. A right-port access to DEPTH-1 with rCe=1 and rOe=1 returns rIntN high, whatever the value of rWe.
- R6: If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: With intrEn=0 neither flag changes. Both doorbell words are still written and read as ordinary data.
- R8: A message written to a doorbell word is stored and read back unchanged, like any other word.
- R9: An access to a port's doorbell word without output enable leaves that port's flag unchanged. A port that writes its own doorbell word does not set its own flag.
- R10: When both ports write the same address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intrEn | input | 1 | Doorbell function enable |
| lCe | input | 1 | Left chip enable |
| lWe | input | 1 | Left write enable |
| lOe | input | 1 | Left output enable (qualifies the doorbell clear) |
| lAddr | input | ADDR_W (12) | Left address |
| lWrData | input | DATA_W (18) | Left write data |
| lRdData | output | DATA_W (18) | Left registered read data |
| lIntN | output | 1 | Left interrupt, active low |
| rCe | input | 1 | Right chip enable |
| rWe | input | 1 | Right write enable |
| rOe | input | 1 | Right output enable (qualifies the doorbell clear) |
| rAddr | input | ADDR_W (12) | Right address |
| rWrData | input | DATA_W (18) | Right write data |
| rRdData | output | DATA_W (18) | Right registered read data |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach from the ports is a set and a clear of the same flag landing in the same cycle. The two ports must act on one doorbell word together while that flag is already raised. A directed step first rings the doorbell. It then drives the remote write and the local enabled read into the same cycle.

Random traffic draws a quarter of its addresses from the two doorbell words, so this case and cross-port read/write collisions also arise by chance. Some stretches of the random traffic run with the enable off.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic wrL;
    logic wrR;
    logic rdL;
    logic rdR;
    logic setL;
    logic clrL;
    logic setR;
    logic clrR;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int ADDR_W = 12
) (
  input  logic              intrEn,
  input  logic              lCe,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCe,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  output mbx_pkg::mbxStrobes_t strobes
);
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

  logic lWrite, rWrite, lOpen, rOpen;

  always_comb begin
    lWrite = lCe && lWe;
    rWrite = rCe && rWe;
    lOpen  = lCe && lOe;
    rOpen  = rCe && rOe;
    strobes.wrL  = lWrite;
    strobes.wrR  = rWrite;
    strobes.rdL  = lCe && !lWe;
    strobes.rdR  = rCe && !rWe;
    strobes.setL = intrEn && rWrite && (rAddr == BOX_L);
    strobes.clrL = intrEn && lOpen  && (lAddr == BOX_L);
    strobes.setR = intrEn && lWrite && (lAddr == BOX_R);
    strobes.clrR = intrEn && rOpen  && (rAddr == BOX_R);
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbx_pkg::mbxStrobes_t strobes,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData,
  output logic              lIntN,
  output logic              rIntN
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic flagL, flagR;

  // right written first so a same-address left write takes the word
  always_ff @(posedge clk) begin
    if (strobes.wrR) mem[rAddr] <= rWrData;
    if (strobes.wrL) mem[lAddr] <= lWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdData <= '0;
      rRdData <= '0;
    end else begin
      if (strobes.rdL) lRdData <= mem[lAddr];
      if (strobes.rdR) rRdData <= mem[rAddr];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagL <= 1'b0;
      flagR <= 1'b0;
    end else begin
      if (strobes.setL)      flagL <= 1'b1;
      else if (strobes.clrL) flagL <= 1'b0;
      if (strobes.setR)      flagR <= 1'b1;
      else if (strobes.clrR) flagR <= 1'b0;
    end
  end

  assign lIntN = !flagL;
  assign rIntN = !flagR;
endmodule

// File: rtl/mbx_doorbell_ram.sv
module mbx_doorbell_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intrEn,
  input  logic              lCe,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lIntN,
  input  logic              rCe,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rIntN
);
  mbx_pkg::mbxStrobes_t strobes;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .intrEn(intrEn), .lCe(lCe), .lWe(lWe), .lOe(lOe), .lAddr(lAddr),
    .rCe(rCe), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .strobes(strobes)
  );

  mbx_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lAddr(lAddr), .lWrData(lWrData), .rAddr(rAddr), .rWrData(rWrData),
    .lRdData(lRdData), .rRdData(rRdData), .lIntN(lIntN), .rIntN(rIntN)
  );
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              intrEn,
  input logic              lCe,
  input logic              lWe,
  input logic              lOe,
  input logic [ADDR_W-1:0] lAddr,
  input logic [DATA_W-1:0] lRdData,
  input logic              lIntN,
  input logic              rCe,
  input logic              rWe,
  input logic              rOe,
  input logic [ADDR_W-1:0] rAddr,
  input logic [DATA_W-1:0] rRdData,
  input logic              rIntN
);
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

  p_ring_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intrEn && rCe && rWe && rAddr == BOX_L) |=> !lIntN);

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lIntN) |-> $past(intrEn && rCe && rWe && rAddr == BOX_L));

  p_ack_left_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intrEn && lCe && lOe && lAddr == BOX_L &&
     !(rCe && rWe && rAddr == BOX_L)) |=> lIntN);

  p_ring_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intrEn && lCe && lWe && lAddr == BOX_R) |=> !rIntN);

  p_ack_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intrEn && rCe && rOe && rAddr == BOX_R &&
     !(lCe && lWe && lAddr == BOX_R)) |=> rIntN);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !intrEn |=> ($stable(lIntN) && $stable(rIntN)));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(lCe && !lWe) |=> $stable(lRdData));

  p_rd_hold_right_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rCe && !rWe) |=> $stable(rRdData));
endmodule

bind mbx_doorbell_ram mbx_doorbell_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbx_doorbell_ram_bench.sv
module mbx_doorbell_ram_bench;
  localparam int AW = 12;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);
  localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intrEn = 1'b1;
  logic lCe = 0, lWe = 0, lOe = 0, rCe = 0, rWe = 0, rOe = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWrData = '0, rWrData = '0;
  logic [DW-1:0] lRdData, rRdData;
  logic lIntN, rIntN;

  always #10 clk = ~clk;

  mbx_doorbell_ram #(.ADDR_W(AW), .DATA_W(DW)) u_mbx_doorbell_ram (
    .clk(clk), .rstN(rstN), .intrEn(intrEn),
    .lCe(lCe), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWrData(lWrData),
    .lRdData(lRdData), .lIntN(lIntN),
    .rCe(rCe), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWrData(rWrData),
    .rRdData(rRdData), .rIntN(rIntN)
  );

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];
  logic known [DEPTH];
  logic [DW-1:0] expL = '0, expR = '0;
  logic okL = 1'b1, okR = 1'b1;
  logic fL = 1'b0, fR = 1'b0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic nextFlag(input logic cur, input logic setIt, input logic clrIt);
    if (setIt) return 1'b1;
    if (clrIt) return 1'b0;
    return cur;
  endfunction

  function automatic logic [AW-1:0] pickAddr();
    int r = $urandom % 8;
    if (r == 0) return BOX_L;
    if (r == 1) return BOX_R;
    return AW'($urandom % 16);
  endfunction

  // one clock: update the model from the inputs, then compare at the negedge
  task automatic step();
    logic sL, cL, sR, cR;
    @(posedge clk);
    if (lCe && !lWe) begin expL = model[lAddr]; okL = known[lAddr]; end
    if (rCe && !rWe) begin expR = model[rAddr]; okR = known[rAddr]; end
    sL = intrEn && rCe && rWe && rAddr == BOX_L;
    cL = intrEn && lCe && lOe && lAddr == BOX_L;
    sR = intrEn && lCe && lWe && lAddr == BOX_R;
    cR = intrEn && rCe && rOe && rAddr == BOX_R;
    fL = nextFlag(fL, sL, cL);
    fR = nextFlag(fR, sR, cR);
    if (rCe && rWe) begin model[rAddr] = rWrData; known[rAddr] = 1'b1; end
    if (lCe && lWe) begin model[lAddr] = lWrData; known[lAddr] = 1'b1; end
    @(negedge clk);
    if (okL) check("R2 left read", lRdData, expL);
    if (okR) check("R2 right read", rRdData, expR);
    check("R3 lIntN", DW'(lIntN), DW'(!fL));
    check("R5 rIntN", DW'(rIntN), DW'(!fR));
  endtask

  task automatic idle();
    lCe = 0; lWe = 0; lOe = 0; rCe = 0; rWe = 0; rOe = 0;
  endtask

  task automatic lOp(input logic ce, input logic we, input logic oe,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    lCe = ce; lWe = we; lOe = oe; lAddr = a; lWrData = d;
  endtask

  task automatic rOp(input logic ce, input logic we, input logic oe,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    rCe = ce; rWe = we; rOe = oe; rAddr = a; rWrData = d;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int i = 0; i < DEPTH; i++) begin model[i] = '0; known[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lIntN", DW'(lIntN), DW'(1));
    check("R1 rIntN", DW'(rIntN), DW'(1));
    check("R1 lRdData", lRdData, '0);
    check("R1 rRdData", rRdData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: cross-port write then read
    lOp(1, 1, 0, 12'h005, 18'h12345); step(); idle();
    rOp(1, 0, 1, 12'h005, '0); step(); idle();
    check("R2 cross read", rRdData, 18'h12345);

    // R3 and R9: right rings the left doorbell; its own flag stays
    rOp(1, 1, 0, BOX_L, 18'h2abcd); step(); idle();
    check("R3 set", DW'(lIntN), DW'(0));
    check("R9 no self set right", DW'(rIntN), DW'(1));

    // R9: read without output enable does not clear
    lOp(1, 0, 0, BOX_L, '0); step(); idle();
    check("R9 no oe keeps flag", DW'(lIntN), DW'(0));

    // R4 and R8: enabled read clears and returns the message
    lOp(1, 0, 1, BOX_L, '0); step(); idle();
    check("R4 clear", DW'(lIntN), DW'(1));
    check("R8 message", lRdData, 18'h2abcd);

    // R4: clear with write strobe high
    rOp(1, 1, 0, BOX_L, 18'h00001); step(); idle();
    lOp(1, 1, 1, BOX_L, 18'h00777); step(); idle();
    check("R4 clear on write", DW'(lIntN), DW'(1));

    // R5: left rings right, right acknowledges
    lOp(1, 1, 0, BOX_R, 18'h3c3c3); step(); idle();
    check("R5 set", DW'(rIntN), DW'(0));
    check("R9 no self set left", DW'(lIntN), DW'(1));
    rOp(1, 0, 1, BOX_R, '0); step(); idle();
    check("R5 clear", DW'(rIntN), DW'(1));
    check("R8 right message", rRdData, 18'h3c3c3);

    // R6: set and clear together while flag is up
    rOp(1, 1, 0, BOX_L, 18'h11111); step(); idle();
    rOp(1, 1, 0, BOX_L, 18'h22222); lOp(1, 0, 1, BOX_L, '0); step(); idle();
    check("R6 set wins", DW'(lIntN), DW'(0));
    check("R6 old data read", lRdData, 18'h11111);

    // R7: disabled flags freeze; words still storage
    intrEn = 1'b0;
    lOp(1, 0, 1, BOX_L, '0); step(); idle();
    check("R7 no clear", DW'(lIntN), DW'(0));
    lOp(1, 1, 0, BOX_R, 18'h05a5a); step(); idle();
    check("R7 no set", DW'(rIntN), DW'(1));
    rOp(1, 0, 1, BOX_R, '0); step(); idle();
    check("R7 plain data", rRdData, 18'h05a5a);
    intrEn = 1'b1;
    lOp(1, 0, 1, BOX_L, '0); step(); idle();

    // R10: simultaneous write same address
    lOp(1, 1, 0, 12'h009, 18'h0aaaa); rOp(1, 1, 0, 12'h009, 18'h15555); step(); idle();
    lOp(1, 0, 0, 12'h009, '0); step(); idle();
    check("R10 left wins", lRdData, 18'h0aaaa);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      intrEn = ((n / 500) % 4) != 3;
      lOp(($urandom % 5) != 0, ($urandom % 5) < 2, $urandom % 2, pickAddr(), DW'($urandom));
      rOp(($urandom % 5) != 0, ($urandom % 5) < 2, $urandom % 2, pickAddr(), DW'($urandom));
      step();
    end
    idle();
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule